// File: doc/BRIEF.md
# Fuse Array Auto-Read Controller

This block lets software fetch data from a one-time-programmable fuse array through a small register window. Software first puts a word address in the control register and raises an address-latch bit. It then raises a start bit. Once started, the block talks to the fuse array, which needs several cycles per access, and shows a busy flag for as long as the access lasts. When busy drops, the fetched word is waiting in a separate data register.

Reads only run when the array is powered up and automatic reading is enabled. Both conditions are bits in the control register, and power-down is set out of reset. A build-time parameter chooses the access width. In word mode each access returns four bytes and the address counts words. In byte mode each access returns one byte and the address counts bytes. A separate register holds an encrypt-enable bit. Software clears that bit before reading so that the array's raw contents come back.

Top module: `efz_autoread_top`

## Requirements
- R1: After reset the control register (offset 0) reads 0x0000_0008: only the power-down bit (bit 3) is 1. The data register (offset 1) and the crypt register (offset 2) read 0.
- R2: The read address comes from the control-register field at bits [16 +: ADDR_W]. It is captured only by a write that takes the address-latch bit (bit 0) from 0 to 1. Writes to the field with that bit at 0, or with it already at 1, leave the read address unchanged.
- R3: A control write that takes the start bit (bit 1) from 0 to 1 begins a read, provided the written value has enable (bit 2) at 1 and power-down (bit 3) at 0. The busy bit (bit 4) reads 1 on the first register read after that write.
- R4: Busy stays 1 for exactly LAT clock cycles (default 8) after the start write, then returns to 0.
- R5: When busy falls, the data register holds the array contents at the latched address. Fuse byte i holds the low 8 bits of (i*29), XOR 0xA5. In word mode, word a is bytes 4a..4a+3, with the lowest byte index in bits [7:0]. In byte mode the register holds byte a in bits [7:0] and zeros above.
- R6: The data register does not change while busy is 1. It changes only in the cycle in which busy falls.
- R7: A start write whose value has enable at 0, or power-down at 1, is ignored: busy stays 0 and the data register keeps its value.
- R8: A start edge written while busy is 1 is ignored. Busy still falls LAT cycles after the first start, no second access follows, and the result is the one for the address latched before the first start.
- R9: Writing the start bit as 1 again, while it is still 1, does not begin a new read.
- R10: Bit 0 of the crypt register (offset 2) is read/write and resets to 0. Clearing it lets reads return the raw array contents.
- R11: While the read strobe is 0, read data is 0. Offset 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from offset and strobe |

## Verification
The bench mixes random addresses with targeted sequences and looks at these corner cases:
- Address-field writes with no latch edge, or with the latch bit held high. A design that captures the address on the level of the bit, rather than on its rising edge, returns the wrong word.
- Start edges given while the array is powered down or auto-read is disabled. A design that ignores these gates raises busy.
- A second start edge given in the middle of an access. A design that restarts here stretches busy beyond LAT cycles or returns the newly latched address.
- A start bit written as 1 twice in a row. A design that starts on the level of the bit launches a spurious second read.

// File: rtl/efz_pkg.sv
package efz_pkg;

  localparam int REG_AW   = 2;
  localparam int REG_DW   = 32;

  localparam int B_SET    = 0;
  localparam int B_START  = 1;
  localparam int B_EN     = 2;
  localparam int B_PD     = 3;
  localparam int B_BUSY   = 4;
  localparam int ADDR_LSB = 16;

  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_DATA  = 2'd1,
    OFS_CRYPT = 2'd2,
    OFS_RSVD  = 2'd3
  } reg_ofs_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } sq_state_e;

  function automatic logic [7:0] fuse_byte(input logic [31:0] idx);
    logic [31:0] prod;
    prod = idx * 32'd29;
    return prod[7:0] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/efz_fuse_array.sv
module efz_fuse_array
  import efz_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int GRAN   = 4,
  parameter int LAT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ack,
  output logic [REG_DW-1:0] ack_data
);

  localparam int CW    = $clog2(LAT + 1);
  localparam int LANES = REG_DW / 8;

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       base_idx;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (req) begin
      cnt_d  = CW'(LAT);
      addr_d = req_addr;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign ack      = (cnt_q == CW'(1));
  assign base_idx = 32'(addr_q) * 32'(GRAN);

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      if (k < GRAN) begin : g_live
        assign ack_data[8*k +: 8] = fuse_byte(base_idx + 32'(k));
      end else begin : g_zero
        assign ack_data[8*k +: 8] = 8'h00;
      end
    end
  endgenerate

endmodule

// File: rtl/efz_regs.sv
module efz_regs
  import efz_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              busy,
  input  logic [REG_DW-1:0] data_q,
  output logic [REG_DW-1:0] rdata,
  output logic              go,
  output logic [ADDR_W-1:0] lat_addr
);

  logic [ADDR_W-1:0] afield_q, afield_d, alat_q, alat_d;
  logic set_q, set_d, start_q, start_d, en_q, en_d, pd_q, pd_d, enc_q, enc_d;
  logic ctrl_wr, crypt_wr;
  logic [ADDR_W-1:0] wfield;
  logic unused_wdata;

  assign ctrl_wr      = wr && (addr == OFS_CTRL);
  assign crypt_wr     = wr && (addr == OFS_CRYPT);
  assign wfield       = wdata[ADDR_LSB +: ADDR_W];
  assign unused_wdata = ^wdata;

  always_comb begin
    afield_d = afield_q;
    alat_d   = alat_q;
    set_d    = set_q;
    start_d  = start_q;
    en_d     = en_q;
    pd_d     = pd_q;
    enc_d    = enc_q;
    go       = 1'b0;
    if (ctrl_wr) begin
      afield_d = wfield;
      set_d    = wdata[B_SET];
      start_d  = wdata[B_START];
      en_d     = wdata[B_EN];
      pd_d     = wdata[B_PD];
      if (wdata[B_SET] && !set_q) begin
        alat_d = wfield;
      end
      if (wdata[B_START] && !start_q && wdata[B_EN] && !wdata[B_PD] && !busy) begin
        go = 1'b1;
      end
    end
    if (crypt_wr) begin
      enc_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afield_q <= '0;
      alat_q   <= '0;
      set_q    <= 1'b0;
      start_q  <= 1'b0;
      en_q     <= 1'b0;
      pd_q     <= 1'b1;
      enc_q    <= 1'b0;
    end else begin
      afield_q <= afield_d;
      alat_q   <= alat_d;
      set_q    <= set_d;
      start_q  <= start_d;
      en_q     <= en_d;
      pd_q     <= pd_d;
      enc_q    <= enc_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        OFS_CTRL: begin
          rdata[ADDR_LSB +: ADDR_W] = afield_q;
          rdata[B_BUSY]             = busy;
          rdata[B_PD]               = pd_q;
          rdata[B_EN]               = en_q;
          rdata[B_START]            = start_q;
          rdata[B_SET]              = set_q;
        end
        OFS_DATA:  rdata = data_q;
        OFS_CRYPT: rdata[0] = enc_q;
        default:   rdata = '0;
      endcase
    end
  end

  assign lat_addr = alat_q;

endmodule

// File: rtl/efz_seq.sv
module efz_seq
  import efz_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              arr_ack,
  input  logic [REG_DW-1:0] arr_data,
  output logic              busy,
  output logic [REG_DW-1:0] data_q,
  output logic              arr_req,
  output logic [ADDR_W-1:0] arr_addr
);

  sq_state_e         state_q, state_d;
  logic [REG_DW-1:0] data_d;

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    arr_req = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (go) begin
          arr_req = 1'b1;
          state_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (arr_ack) begin
          data_d  = arr_data;
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  assign busy     = (state_q == SQ_WAIT);
  assign arr_addr = lat_addr;

endmodule

// File: rtl/efz_autoread_top.sv
module efz_autoread_top
  import efz_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit BYTE_MODE = 1'b0,
  parameter int LAT       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  localparam int GRAN = BYTE_MODE ? 1 : 4;

  logic [1:0]        rsync_q;
  logic              rst_sync_n;
  logic              go, busy, arr_req, arr_ack;
  logic [ADDR_W-1:0] lat_addr, arr_addr;
  logic [REG_DW-1:0] data_q, arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rsync_q[1];

  efz_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .data_q   (data_q),
    .rdata    (reg_rdata),
    .go       (go),
    .lat_addr (lat_addr)
  );

  efz_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (go),
    .lat_addr (lat_addr),
    .arr_ack  (arr_ack),
    .arr_data (arr_data),
    .busy     (busy),
    .data_q   (data_q),
    .arr_req  (arr_req),
    .arr_addr (arr_addr)
  );

  efz_fuse_array #(.ADDR_W(ADDR_W), .GRAN(GRAN), .LAT(LAT)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (arr_req),
    .req_addr (arr_addr),
    .ack      (arr_ack),
    .ack_data (arr_data)
  );

endmodule

// File: rtl/efz_chk.sv
module efz_chk #(
  parameter int LAT = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [2:0]  ctl_bits,
  input logic        busy,
  input logic [31:0] data,
  input logic        arr_req
);

  localparam int BW = $clog2(LAT + 2);

  logic [BW-1:0] bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (busy) begin
      if (bcnt_q != {BW{1'b1}}) bcnt_q <= bcnt_q + 1'b1;
    end else begin
      bcnt_q <= '0;
    end
  end

  AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd0 && ctl_bits[0] && ctl_bits[1] && !ctl_bits[2])) // R7
    else $error("busy rose without an enabled, powered start write");

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BW'(LAT)) // R4
    else $error("busy held longer than the access latency");

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data)) // R6
    else $error("data register moved during an access");

  AST_DATA_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> $fell(busy)) // R6
    else $error("data register moved outside completion");

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> !busy) // R8
    else $error("array request issued during an access");

endmodule

bind efz_autoread_top efz_chk #(.LAT(LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .ctl_bits (reg_wdata[3:1]),
  .busy     (busy),
  .data     (data_q),
  .arr_req  (arr_req)
);

// File: tb/tb_efz_autoread_top.sv
module tb_efz_autoread_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int LAT        = 8;
  localparam int GRAN       = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks;
  int errors;
  int cyc;

  efz_autoread_top #(.ADDR_W(ADDR_W), .BYTE_MODE(1'b0), .LAT(LAT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] fb(input int idx);
    logic [31:0] p;
    p = idx * 29;
    return p[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < GRAN; k++) w[8*k +: 8] = fb(a * GRAN + k);
    return w;
  endfunction

  function automatic logic [31:0] ctrl(input int a, input bit set, input bit start,
                                       input bit en, input bit pd);
    logic [31:0] v;
    v = '0;
    v[16 +: ADDR_W] = ADDR_W'(a);
    v[0] = set;
    v[1] = start;
    v[2] = en;
    v[3] = pd;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [1:0] ofs, input logic [31:0] v);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = ofs;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] ofs, output logic [31:0] v);
    reg_addr = ofs;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(output int ncyc);
    logic [31:0] v;
    int t0;
    t0 = cyc;
    rd_reg(2'd0, v);
    while (v[4] && (cyc - t0) < 1000) begin
      @(negedge clk);
      rd_reg(2'd0, v);
    end
    ncyc = cyc - t0;
  endtask

  task automatic latch_addr(input int a);
    wr_reg(2'd0, ctrl(a, 1'b1, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(a, 1'b0, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic full_read(input int a, input string req);
    logic [31:0] v;
    int n;
    latch_addr(a);
    wr_reg(2'd0, ctrl(a, 1'b0, 1'b1, 1'b1, 1'b0));
    rd_reg(2'd0, v);
    check({req, "/R3 busy after start"}, 32'(v[4]), 32'd1);
    wait_idle(n);
    check({req, "/R4 busy length"}, 32'(n), 32'(LAT));
    rd_reg(2'd1, v);
    check({req, "/R5 data"}, v, exp_word(a));
    wr_reg(2'd0, ctrl(a, 1'b0, 1'b0, 1'b1, 1'b0));
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] prev;
    int n;
    int seed;
    checks    = 0;
    errors    = 0;
    cyc       = 0;
    seed      = $urandom(32'd20240611);
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b1;
    reg_addr  = 2'd0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd_reg(2'd0, v); check("R1 ctrl reset", v, 32'h0000_0008);
    rd_reg(2'd1, v); check("R1 data reset", v, 32'h0);
    rd_reg(2'd2, v); check("R1 crypt reset", v, 32'h0);

    // R7 start while still powered down
    wr_reg(2'd0, ctrl(0, 1'b0, 1'b1, 1'b1, 1'b1));
    rd_reg(2'd0, v); check("R7 start with power-down", 32'(v[4]), 32'd0);
    wr_reg(2'd0, ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd2, 32'h0);

    // R2 R3 R4 R5 directed boundaries
    full_read(0, "R2 addr0");
    full_read((1 << ADDR_W) - 1, "R2 addrmax");
    full_read(1, "R5 addr1");

    // R5 random addresses
    for (int i = 0; i < 25; i++) begin
      full_read($urandom_range(0, (1 << ADDR_W) - 1), "R5 random");
    end

    // R2 field write without latch edge
    latch_addr(5);
    wr_reg(2'd0, ctrl(9, 1'b0, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(9, 1'b0, 1'b1, 1'b1, 1'b0));
    wait_idle(n);
    rd_reg(2'd1, v); check("R2 no latch without set edge", v, exp_word(5));
    wr_reg(2'd0, ctrl(9, 1'b0, 1'b0, 1'b1, 1'b0));

    // R2 latch bit held high
    wr_reg(2'd0, ctrl(7, 1'b1, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(11, 1'b1, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(11, 1'b0, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(11, 1'b0, 1'b1, 1'b1, 1'b0));
    wait_idle(n);
    rd_reg(2'd1, v); check("R2 held latch bit", v, exp_word(7));
    wr_reg(2'd0, ctrl(11, 1'b0, 1'b0, 1'b1, 1'b0));

    // R7 enable off
    rd_reg(2'd1, prev);
    latch_addr(3);
    wr_reg(2'd0, ctrl(3, 1'b0, 1'b0, 1'b0, 1'b0));
    wr_reg(2'd0, ctrl(3, 1'b0, 1'b1, 1'b0, 1'b0));
    rd_reg(2'd0, v); check("R7 enable off busy", 32'(v[4]), 32'd0);
    repeat (LAT + 4) @(negedge clk);
    rd_reg(2'd0, v); check("R7 enable off busy later", 32'(v[4]), 32'd0);
    rd_reg(2'd1, v); check("R7 enable off data", v, prev);
    wr_reg(2'd0, ctrl(3, 1'b0, 1'b0, 1'b1, 1'b0));

    // R7 power-down set
    wr_reg(2'd0, ctrl(3, 1'b0, 1'b1, 1'b1, 1'b1));
    rd_reg(2'd0, v); check("R7 power-down busy", 32'(v[4]), 32'd0);
    repeat (LAT + 4) @(negedge clk);
    rd_reg(2'd1, v); check("R7 power-down data", v, prev);
    wr_reg(2'd0, ctrl(3, 1'b0, 1'b0, 1'b1, 1'b0));
    full_read(3, "R7 recovery");

    // R8 start edge during an access
    latch_addr(20);
    wr_reg(2'd0, ctrl(20, 1'b0, 1'b1, 1'b1, 1'b0));
    n = cyc;
    wr_reg(2'd0, ctrl(21, 1'b1, 1'b0, 1'b1, 1'b0));
    wr_reg(2'd0, ctrl(21, 1'b0, 1'b1, 1'b1, 1'b0));
    begin
      int n2;
      wait_idle(n2);
      check("R8 busy length with restart", 32'(cyc - n), 32'(LAT));
    end
    rd_reg(2'd1, v); check("R8 first address result", v, exp_word(20));
    repeat (LAT + 4) @(negedge clk);
    rd_reg(2'd0, v); check("R8 no second access", 32'(v[4]), 32'd0);
    rd_reg(2'd1, v); check("R8 data kept", v, exp_word(20));

    // R9 start written as 1 again
    wr_reg(2'd0, ctrl(21, 1'b0, 1'b1, 1'b1, 1'b0));
    rd_reg(2'd0, v); check("R9 held start no busy", 32'(v[4]), 32'd0);
    wr_reg(2'd0, ctrl(21, 1'b0, 1'b0, 1'b1, 1'b0));

    // R10 crypt bit
    wr_reg(2'd2, 32'h1);
    rd_reg(2'd2, v); check("R10 crypt set", v, 32'h1);
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd2, v); check("R10 crypt clear", v, 32'h0);
    full_read(21, "R10 raw read");

    // R11 strobe low and reserved offset
    rd_reg(2'd3, v); check("R11 reserved offset", v, 32'h0);
    reg_rd = 1'b0;
    rd_reg(2'd0, v); check("R11 strobe low", v, 32'h0);
    reg_rd = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule